// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block trains a serial point-to-point link from a single start pulse. It first caps the advertised speed at the first generation and enables training. It then waits for the link to come up. If the allowed generation is the second one, it raises the advertised speed and requests a directed speed change. It waits for the change to finish and for the link to retrain, then reports the negotiated speed read back from the link status register. If any wait runs out, the block pulses two receiver override controls in the PHY before it reports failure.

Every access goes through one of two simple request/response ports. One serves the controller's 32-bit configuration registers and the other serves the PHY's 16-bit internal registers. On each port, a request stays valid, with address, data and direction held stable, until the responder raises ready. At most one request is outstanding. The responder returns exactly one single-cycle response per accepted request, at least one cycle after acceptance. The block accepts that response in any cycle, so the response path has no back-pressure. A write also returns a response, and its data is ignored.

Every register update is a read followed by a write, and the write changes only the targeted field. Default register addresses are capability 0x010, link status 0x014, debug 0x020 and width/speed control 0x030. The PHY receiver override register sits at PHY address 0x1005.

Top module: `link_speed_seq`

## Requirements
- R1: While reset is asserted and right after it, `done`, `fail`, `train_en`, both request valids and `cur_speed` are all zero.
- R2: After `start`, the capability register is read and then written back with bits 3:0 set to 1 and bits 31:4 unchanged. This write happens while `train_en` is still low.
- R3: After that write, `train_en` rises and the debug register is polled. The link counts as up only when bit 4 is 1 and bit 29 is 0 in the same read. No other register is accessed until the link is up. Successive polls are accepted more than POLL_GAP cycles apart.
- R4: `max_gen` value 2 selects the second generation. Any other value (0, 1, 3) skips the speed change: there is no further capability write and no access to the width/speed control register, and the speed is read from link status at once.
- R5: With `max_gen` = 2, after the first link-up the capability register's bits 3:0 are rewritten to 2, with the other bits kept. The width/speed control register is then rewritten with bit 17 set and its other bits kept.
- R6: Width/speed control is then polled until bit 17 reads 0. If it reads 1 on SPD_TRIES consecutive polls, the run fails.
- R7: After bit 17 clears, the link-up wait of R3 is repeated. Link status is then read, `cur_speed` takes its bits 19:16, and `done` rises.
- R8: A link-up wait that sees the link down on LINK_TRIES consecutive debug reads fails the run, so exactly LINK_TRIES debug reads are made.
- R9: On failure, PHY register 0x1005 is read and written back with bits 5 and 3 set and other bits kept. After at least RECOV_CYC cycles it is read again and written back with bits 5 and 3 cleared. Only then does `fail` rise. A successful run makes no PHY access.
- R10: `done` and `fail` are never high together. Each stays high until the next accepted `start`, which clears both. A `start` while a run is in progress is ignored, and so is a `max_gen` change during a run.
- R11: On both request ports, a valid request that is not accepted stays valid with address, data and direction unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| max_gen | input | 2 | Allowed generation, 2 = second generation, others = first only |
| done | output | 1 | Run finished with the link up (sticky) |
| fail | output | 1 | Run failed after receiver recovery (sticky) |
| cur_speed | output | 4 | Speed code read from link status bits 19:16 |
| train_en | output | 1 | Link training enable |
| reg_req_valid | output | 1 | Register request valid |
| reg_req_ready | input | 1 | Register request accepted |
| reg_req_write | output | 1 | 1 = write, 0 = read |
| reg_req_addr | output | REG_AW | Register address |
| reg_req_wdata | output | 32 | Register write data |
| reg_rsp_valid | input | 1 | Register response valid (one cycle) |
| reg_rsp_rdata | input | 32 | Register read data |
| phy_req_valid | output | 1 | PHY request valid |
| phy_req_ready | input | 1 | PHY request accepted |
| phy_req_write | output | 1 | 1 = write, 0 = read |
| phy_req_addr | output | PHY_AW | PHY register address |
| phy_req_wdata | output | PHY_DW | PHY write data |
| phy_rsp_valid | input | 1 | PHY response valid (one cycle) |
| phy_rsp_rdata | input | PHY_DW | PHY read data |

## Verification
The main sequence is swept over all four `max_gen` codes against both a first-generation-only and a second-generation partner. This separates the code that unlocks the speed change from those that must not. It also separates the speed the block requests from the speed actually negotiated. The link model shows a window where the up bit and the training bit are both set, so a design that ignores the training bit leaves the wait too early and is caught. Two failure patterns are also tried. In one the link never comes up, and in the other the speed change bit never clears. They pin the exact poll counts and the receiver override write values and spacing. Ready toggles on both ports throughout, which tests that requests are held while back-pressured. A mid-run restart with a changed `max_gen` shows that a run in progress cannot be disturbed.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam int REG_DW = 32;

  // bit positions decoded by the controller and PHY register files
  localparam int LINK_UP_BIT   = 4;
  localparam int TRAINING_BIT  = 29;
  localparam int SPD_CHG_BIT   = 17;
  localparam int SPD_LSB       = 16;
  localparam int RX_DATA_EN    = 5;
  localparam int RX_PLL_EN     = 3;

  localparam logic [3:0] GEN1 = 4'd1;
  localparam logic [3:0] GEN2 = 4'd2;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CAP_RD,
    ST_CAP_WR,
    ST_LNK_GAP,
    ST_LNK_RD,
    ST_UP_RD,
    ST_UP_WR,
    ST_SC_RD,
    ST_SC_WR,
    ST_SC_GAP,
    ST_SC_POLL,
    ST_STAT_RD,
    ST_RX_RD1,
    ST_RX_WR1,
    ST_RX_HOLD,
    ST_RX_RD2,
    ST_RX_WR2
  } seq_st_t;

  function automatic logic [REG_DW-1:0] put_speed(input logic [REG_DW-1:0] v,
                                                  input logic [3:0] gen);
    return {v[REG_DW-1:4], gen};
  endfunction

endpackage

// File: rtl/lsq_xact.sv
module lsq_xact #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          fin,
  output logic [DW-1:0] rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata
);

  typedef enum logic [1:0] {X_IDLE, X_REQ, X_RSP} x_st_t;
  x_st_t st;

  assign req_valid = (st == X_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= X_IDLE;
      fin       <= 1'b0;
      rdata     <= '0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        X_IDLE: if (go) begin
          req_write <= wr;
          req_addr  <= addr;
          req_wdata <= wdata;
          st        <= X_REQ;
        end
        X_REQ: if (req_ready) st <= X_RSP;
        X_RSP: if (rsp_valid) begin
          rdata <= rsp_rdata;
          fin   <= 1'b1;
          st    <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write))); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == X_IDLE)); // R11

endmodule

// File: rtl/lsq_delay.sv
module lsq_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/link_speed_seq.sv
module link_speed_seq
  import lsq_pkg::*;
#(
  parameter int unsigned REG_AW     = 12,
  parameter int unsigned PHY_AW     = 16,
  parameter int unsigned PHY_DW     = 16,
  parameter int unsigned POLL_GAP   = 100,
  parameter int unsigned LINK_TRIES = 1000,
  parameter int unsigned SPD_TRIES  = 200,
  parameter int unsigned RECOV_CYC  = 250000,
  parameter logic [REG_AW-1:0] CAP_ADDR  = 12'h010,
  parameter logic [REG_AW-1:0] STAT_ADDR = 12'h014,
  parameter logic [REG_AW-1:0] DBG_ADDR  = 12'h020,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 12'h030,
  parameter logic [PHY_AW-1:0] RXOVR_ADDR = 16'h1005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        max_gen,
  output logic              done,
  output logic              fail,
  output logic [3:0]        cur_speed,
  output logic              train_en,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_write,
  output logic [REG_AW-1:0] reg_req_addr,
  output logic [REG_DW-1:0] reg_req_wdata,
  input  logic              reg_rsp_valid,
  input  logic [REG_DW-1:0] reg_rsp_rdata,
  output logic              phy_req_valid,
  input  logic              phy_req_ready,
  output logic              phy_req_write,
  output logic [PHY_AW-1:0] phy_req_addr,
  output logic [PHY_DW-1:0] phy_req_wdata,
  input  logic              phy_rsp_valid,
  input  logic [PHY_DW-1:0] phy_rsp_rdata
);

  localparam int unsigned DLY_MAX = (POLL_GAP > RECOV_CYC) ? POLL_GAP : RECOV_CYC;
  localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
  localparam int unsigned TRY_MAX = (LINK_TRIES > SPD_TRIES) ? LINK_TRIES : SPD_TRIES;
  localparam int unsigned TRY_W   = $clog2(TRY_MAX + 1);
  localparam logic [PHY_DW-1:0] RX_MASK = PHY_DW'((1 << RX_DATA_EN) | (1 << RX_PLL_EN));
  localparam logic [REG_DW-1:0] SC_MASK = REG_DW'(1) << SPD_CHG_BIT;

  seq_st_t st;
  logic [1:0]       gen_q;
  logic             second, issued;
  logic [TRY_W-1:0] tries;

  logic              reg_go, reg_wr, reg_fin;
  logic [REG_AW-1:0] reg_addr_c;
  logic [REG_DW-1:0] reg_wdata_c, reg_rd;
  logic              phy_go, phy_wr, phy_fin;
  logic [PHY_DW-1:0] phy_wdata_c, phy_rd;
  logic              dly_load, dly_zero;
  logic [DLY_W-1:0]  dly_val;
  logic              link_up, sc_busy, link_last, spd_last, fin_any;

  assign fin_any   = reg_fin | phy_fin;
  assign link_up   = reg_rd[LINK_UP_BIT] & ~reg_rd[TRAINING_BIT];
  assign sc_busy   = reg_rd[SPD_CHG_BIT];
  assign link_last = (int'(tries) + 1) >= int'(LINK_TRIES);
  assign spd_last  = (int'(tries) + 1) >= int'(SPD_TRIES);

  // request selection per state
  always_comb begin
    reg_go      = 1'b0;
    reg_wr      = 1'b0;
    reg_addr_c  = CAP_ADDR;
    reg_wdata_c = '0;
    phy_go      = 1'b0;
    phy_wr      = 1'b0;
    phy_wdata_c = '0;
    case (st)
      ST_CAP_RD, ST_UP_RD: reg_go = !issued;
      ST_CAP_WR: begin
        reg_go = !issued; reg_wr = 1'b1; reg_wdata_c = put_speed(reg_rd, GEN1);
      end
      ST_UP_WR: begin
        reg_go = !issued; reg_wr = 1'b1; reg_wdata_c = put_speed(reg_rd, GEN2);
      end
      ST_LNK_RD: begin reg_go = !issued; reg_addr_c = DBG_ADDR; end
      ST_SC_RD, ST_SC_POLL: begin reg_go = !issued; reg_addr_c = CTRL_ADDR; end
      ST_SC_WR: begin
        reg_go = !issued; reg_wr = 1'b1; reg_addr_c = CTRL_ADDR;
        reg_wdata_c = reg_rd | SC_MASK;
      end
      ST_STAT_RD: begin reg_go = !issued; reg_addr_c = STAT_ADDR; end
      ST_RX_RD1, ST_RX_RD2: phy_go = !issued;
      ST_RX_WR1: begin phy_go = !issued; phy_wr = 1'b1; phy_wdata_c = phy_rd | RX_MASK; end
      ST_RX_WR2: begin phy_go = !issued; phy_wr = 1'b1; phy_wdata_c = phy_rd & ~RX_MASK; end
      default: ;
    endcase
  end

  always_comb begin
    dly_load = fin_any && (st == ST_CAP_WR || st == ST_LNK_RD || st == ST_SC_WR ||
                           st == ST_SC_POLL || st == ST_RX_WR1);
    dly_val  = (st == ST_RX_WR1) ? DLY_W'(RECOV_CYC) : DLY_W'(POLL_GAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      gen_q     <= '0;
      second    <= 1'b0;
      issued    <= 1'b0;
      tries     <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      cur_speed <= '0;
      train_en  <= 1'b0;
    end else begin
      if (fin_any)               issued <= 1'b0;
      else if (reg_go || phy_go) issued <= 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          done      <= 1'b0;
          fail      <= 1'b0;
          cur_speed <= '0;
          train_en  <= 1'b0;
          gen_q     <= max_gen;
          second    <= 1'b0;
          st        <= ST_CAP_RD;
        end
        ST_CAP_RD: if (reg_fin) st <= ST_CAP_WR;
        ST_CAP_WR: if (reg_fin) begin
          train_en <= 1'b1;
          tries    <= '0;
          st       <= ST_LNK_GAP;
        end
        ST_LNK_GAP: if (dly_zero) st <= ST_LNK_RD;
        ST_LNK_RD: if (reg_fin) begin
          if (link_up) begin
            tries <= '0;
            st    <= (second || gen_q != 2'd2) ? ST_STAT_RD : ST_UP_RD;
          end else if (link_last) begin
            st <= ST_RX_RD1;
          end else begin
            tries <= tries + 1'b1;
            st    <= ST_LNK_GAP;
          end
        end
        ST_UP_RD: if (reg_fin) st <= ST_UP_WR;
        ST_UP_WR: if (reg_fin) st <= ST_SC_RD;
        ST_SC_RD: if (reg_fin) st <= ST_SC_WR;
        ST_SC_WR: if (reg_fin) begin
          tries <= '0;
          st    <= ST_SC_GAP;
        end
        ST_SC_GAP: if (dly_zero) st <= ST_SC_POLL;
        ST_SC_POLL: if (reg_fin) begin
          if (!sc_busy) begin
            second <= 1'b1;
            tries  <= '0;
            st     <= ST_LNK_GAP;
          end else if (spd_last) begin
            st <= ST_RX_RD1;
          end else begin
            tries <= tries + 1'b1;
            st    <= ST_SC_GAP;
          end
        end
        ST_STAT_RD: if (reg_fin) begin
          cur_speed <= reg_rd[SPD_LSB +: 4];
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_RX_RD1: if (phy_fin) st <= ST_RX_WR1;
        ST_RX_WR1: if (phy_fin) st <= ST_RX_HOLD;
        ST_RX_HOLD: if (dly_zero) st <= ST_RX_RD2;
        ST_RX_RD2: if (phy_fin) st <= ST_RX_WR2;
        ST_RX_WR2: if (phy_fin) begin
          fail <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  lsq_xact #(.AW(REG_AW), .DW(REG_DW)) reg_port_i (
    .clk(clk), .rst_n(rst_n), .go(reg_go), .wr(reg_wr), .addr(reg_addr_c),
    .wdata(reg_wdata_c), .fin(reg_fin), .rdata(reg_rd),
    .req_valid(reg_req_valid), .req_ready(reg_req_ready), .req_write(reg_req_write),
    .req_addr(reg_req_addr), .req_wdata(reg_req_wdata),
    .rsp_valid(reg_rsp_valid), .rsp_rdata(reg_rsp_rdata)
  );

  lsq_xact #(.AW(PHY_AW), .DW(PHY_DW)) phy_port_i (
    .clk(clk), .rst_n(rst_n), .go(phy_go), .wr(phy_wr), .addr(RXOVR_ADDR),
    .wdata(phy_wdata_c), .fin(phy_fin), .rdata(phy_rd),
    .req_valid(phy_req_valid), .req_ready(phy_req_ready), .req_write(phy_req_write),
    .req_addr(phy_req_addr), .req_wdata(phy_req_wdata),
    .rsp_valid(phy_rsp_valid), .rsp_rdata(phy_rsp_rdata)
  );

  lsq_delay #(.W(DLY_W)) pacer_i (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .zero(dly_zero)
  );

  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R10
  AST_CAP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && reg_req_write && reg_req_addr == CAP_ADDR) |->
    (reg_req_wdata[3:0] == GEN1 || reg_req_wdata[3:0] == GEN2)); // R2
  AST_POLL_TRAINING: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && reg_req_addr == DBG_ADDR) |-> train_en); // R3
  AST_SC_GEN2_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_valid && reg_req_addr == CTRL_ADDR) |-> (gen_q == 2'd2)); // R4
  AST_PHY_ON_FAIL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_valid |-> (!done && !fail)); // R9

endmodule

// File: tb/link_speed_seq_tb_top.sv
module link_speed_seq_tb_top;

  localparam int POLL_GAP   = 6;
  localparam int LINK_TRIES = 40;
  localparam int SPD_TRIES  = 200;
  localparam int RECOV_CYC  = 60;
  localparam logic [11:0] A_CAP = 12'h010, A_STAT = 12'h014, A_DBG = 12'h020, A_CTRL = 12'h030;
  localparam logic [31:0] CAP_INIT  = 32'h1234_5670;
  localparam logic [31:0] CTRL_INIT = 32'h0000_0C0F;
  localparam logic [15:0] PHY_INIT  = 16'hC3D7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] max_gen = 2'd0;
  logic done, fail, train_en;
  logic [3:0] cur_speed;
  logic reg_req_valid, reg_req_ready, reg_req_write, reg_rsp_valid;
  logic [11:0] reg_req_addr;
  logic [31:0] reg_req_wdata, reg_rsp_rdata;
  logic phy_req_valid, phy_req_ready, phy_req_write, phy_rsp_valid;
  logic [15:0] phy_req_addr, phy_req_wdata, phy_rsp_rdata;

  always #5 clk = ~clk;

  link_speed_seq #(
    .POLL_GAP(POLL_GAP), .LINK_TRIES(LINK_TRIES), .SPD_TRIES(SPD_TRIES), .RECOV_CYC(RECOV_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .max_gen(max_gen),
    .done(done), .fail(fail), .cur_speed(cur_speed), .train_en(train_en),
    .reg_req_valid(reg_req_valid), .reg_req_ready(reg_req_ready),
    .reg_req_write(reg_req_write), .reg_req_addr(reg_req_addr),
    .reg_req_wdata(reg_req_wdata), .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_rdata(reg_rsp_rdata),
    .phy_req_valid(phy_req_valid), .phy_req_ready(phy_req_ready),
    .phy_req_write(phy_req_write), .phy_req_addr(phy_req_addr),
    .phy_req_wdata(phy_req_wdata), .phy_rsp_valid(phy_rsp_valid),
    .phy_rsp_rdata(phy_rsp_rdata)
  );

  // model controls, driven by the stimulus process only
  logic model_init = 1'b0;
  int   mode = 0;      // 0 normal, 1 link never up, 2 speed change stuck
  int   partner = 1;   // highest generation the partner supports

  // link and register model state
  logic [31:0] cap, ctrl;
  logic [15:0] phy_reg;
  logic [3:0]  speed;
  int cyc = 0, train_cnt = 0, sc_cnt = 0;
  int dbg_rd, ctrl_rd, ctrl_wr, cap_wr, cap_early_bad, bad_up_order, hold_bad;
  int phy_rd_n, phy_wr_n, phy_addr_bad, t_w1, t_r2, last_dbg_cyc, min_gap;
  logic [31:0] ctrl_w_val, last_dbg;
  logic [15:0] phy_w1, phy_w2;
  logic pend_r, pend_p;
  logic [11:0] pend_ra; logic [31:0] pend_rd; logic pend_rw;
  logic [15:0] pend_pa, pend_pd; logic pend_pw;

  function automatic logic [31:0] dbg_value(int md, logic ten, int tc);
    logic [31:0] v;
    v = 32'h0000_0100;
    if (ten) begin
      if (md == 1)      v[29] = 1'b1;
      else if (tc < 20) v[29] = 1'b1;
      else if (tc < 25) begin v[29] = 1'b1; v[4] = 1'b1; end
      else              v[4] = 1'b1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reg_req_ready <= (cyc % 3) != 1;
    phy_req_ready <= (cyc % 2) == 0;
    reg_rsp_valid <= 1'b0;
    phy_rsp_valid <= 1'b0;
    // request hold check
    if (pend_r && (!reg_req_valid || reg_req_addr != pend_ra ||
                   reg_req_wdata != pend_rd || reg_req_write != pend_rw)) hold_bad <= hold_bad + 1;
    if (pend_p && (!phy_req_valid || phy_req_addr != pend_pa ||
                   phy_req_wdata != pend_pd || phy_req_write != pend_pw)) hold_bad <= hold_bad + 1;
    pend_r <= reg_req_valid && !reg_req_ready;
    pend_ra <= reg_req_addr; pend_rd <= reg_req_wdata; pend_rw <= reg_req_write;
    pend_p <= phy_req_valid && !phy_req_ready;
    pend_pa <= phy_req_addr; pend_pd <= phy_req_wdata; pend_pw <= phy_req_write;

    if (!train_en) train_cnt <= 0;
    else if (train_cnt < 100000) train_cnt <= train_cnt + 1;
    if (sc_cnt != 0) begin
      sc_cnt <= sc_cnt - 1;
      if (sc_cnt == 1) begin
        ctrl[17]  <= 1'b0;
        speed     <= (cap[3:0] == 4'd2 && partner == 2) ? 4'd2 : 4'd1;
        train_cnt <= 0;
      end
    end

    if (model_init) begin
      cap <= CAP_INIT; ctrl <= CTRL_INIT; phy_reg <= PHY_INIT; speed <= 4'd1;
      sc_cnt <= 0; dbg_rd <= 0; ctrl_rd <= 0; ctrl_wr <= 0; cap_wr <= 0;
      cap_early_bad <= 0; bad_up_order <= 0; hold_bad <= 0;
      phy_rd_n <= 0; phy_wr_n <= 0; phy_addr_bad <= 0; t_w1 <= 0; t_r2 <= 0;
      last_dbg_cyc <= -1; min_gap <= 1000000; ctrl_w_val <= '0; last_dbg <= '0;
      phy_w1 <= '0; phy_w2 <= '0;
    end else begin
      if (reg_req_valid && reg_req_ready) begin
        reg_rsp_valid <= 1'b1;
        reg_rsp_rdata <= 32'hDEAD_BEEF;
        if (reg_req_write) begin
          if (reg_req_addr == A_CAP) begin
            cap <= reg_req_wdata;
            cap_wr <= cap_wr + 1;
            if (cap_wr == 0 && train_en) cap_early_bad <= cap_early_bad + 1;
          end else if (reg_req_addr == A_CTRL) begin
            ctrl <= reg_req_wdata;
            ctrl_wr <= ctrl_wr + 1;
            ctrl_w_val <= reg_req_wdata;
            if (reg_req_wdata[17] && mode != 2) sc_cnt <= 15;
          end
        end else begin
          if (reg_req_addr == A_CAP) begin
            reg_rsp_rdata <= cap;
            if (train_en && !(last_dbg[4] && !last_dbg[29])) bad_up_order <= bad_up_order + 1;
          end else if (reg_req_addr == A_CTRL) begin
            reg_rsp_rdata <= ctrl;
            ctrl_rd <= ctrl_rd + 1;
          end else if (reg_req_addr == A_STAT) begin
            reg_rsp_rdata <= {12'h000, speed, 16'h0041};
            if (!(last_dbg[4] && !last_dbg[29])) bad_up_order <= bad_up_order + 1;
          end else if (reg_req_addr == A_DBG) begin
            reg_rsp_rdata <= dbg_value(mode, train_en, train_cnt);
            last_dbg <= dbg_value(mode, train_en, train_cnt);
            dbg_rd <= dbg_rd + 1;
            if (last_dbg_cyc >= 0 && (cyc - last_dbg_cyc) < min_gap) min_gap <= cyc - last_dbg_cyc;
            last_dbg_cyc <= cyc;
          end
        end
      end
      if (phy_req_valid && phy_req_ready) begin
        phy_rsp_valid <= 1'b1;
        phy_rsp_rdata <= 16'h0000;
        if (phy_req_addr != 16'h1005) phy_addr_bad <= phy_addr_bad + 1;
        if (phy_req_write) begin
          phy_reg <= phy_req_wdata;
          phy_wr_n <= phy_wr_n + 1;
          if (phy_wr_n == 0) begin phy_w1 <= phy_req_wdata; t_w1 <= cyc; end
          else phy_w2 <= phy_req_wdata;
        end else begin
          phy_rsp_rdata <= phy_reg;
          phy_rd_n <= phy_rd_n + 1;
          if (phy_rd_n == 1) t_r2 <= cyc;
        end
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic init_model(input int md, input int pg);
    @(negedge clk);
    mode = md; partner = pg; model_init = 1'b1;
    @(negedge clk);
    model_init = 1'b0;
  endtask

  task automatic pulse_start(input logic [1:0] mg);
    @(negedge clk);
    max_gen = mg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 30000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    init_model(0, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !fail && !train_en && cur_speed == 0 && !reg_req_valid && !phy_req_valid,
        "R1", "outputs in reset", {done, fail, train_en, reg_req_valid, phy_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fail && !train_en && cur_speed == 0, "R1", "outputs after reset",
        {done, fail, train_en, cur_speed}, 0);

    // sweep: every max_gen code against both partners
    for (int mg = 0; mg < 4; mg++) begin
      for (int pg = 1; pg <= 2; pg++) begin
        logic [3:0] exp_spd;
        exp_spd = (mg == 2 && pg == 2) ? 4'd2 : 4'd1;
        init_model(0, pg);
        pulse_start(2'(mg));
        @(negedge clk);
        chk(!done && !fail, "R10", "start clears done/fail", {done, fail}, 0);
        wait_end();
        @(negedge clk);
        chk(done && !fail, "R7", $sformatf("done mg=%0d pg=%0d", mg, pg), {done, fail}, 2'b10);
        chk(cur_speed == exp_spd, "R7", $sformatf("speed mg=%0d pg=%0d", mg, pg), cur_speed, exp_spd);
        chk(cap[3:0] == ((mg == 2) ? 4'd2 : 4'd1), "R5", "cap speed field", cap[3:0], (mg == 2) ? 2 : 1);
        chk(cap[31:4] == CAP_INIT[31:4], "R2", "cap other bits kept", cap, CAP_INIT);
        chk(cap_wr == ((mg == 2) ? 2 : 1), "R4", "cap write count", cap_wr, (mg == 2) ? 2 : 1);
        chk(ctrl_wr == ((mg == 2) ? 1 : 0), "R4", "ctrl write count", ctrl_wr, (mg == 2) ? 1 : 0);
        if (mg == 2)
          chk(ctrl_w_val == (CTRL_INIT | 32'h0002_0000), "R5", "ctrl write value", ctrl_w_val,
              CTRL_INIT | 32'h0002_0000);
        else
          chk(ctrl_rd == 0, "R4", "no ctrl reads", ctrl_rd, 0);
        chk(cap_early_bad == 0, "R2", "cap written before training", cap_early_bad, 0);
        chk(bad_up_order == 0, "R3", "left wait before link up", bad_up_order, 0);
        chk(min_gap > POLL_GAP, "R3", "poll spacing", min_gap, POLL_GAP + 1);
        chk(phy_wr_n == 0 && phy_rd_n == 0, "R9", "no PHY access on success", phy_wr_n + phy_rd_n, 0);
        chk(hold_bad == 0, "R11", "request hold", hold_bad, 0);
      end
    end

    // R10: done sticky, restart while busy ignored
    repeat (30) @(negedge clk);
    chk(done && !fail, "R10", "done sticky", {done, fail}, 2'b10);
    init_model(0, 2);
    pulse_start(2'd2);
    repeat (10) @(negedge clk);
    pulse_start(2'd1);
    wait_end();
    @(negedge clk);
    chk(done && cur_speed == 4'd2, "R10", "restart ignored speed", cur_speed, 2);
    chk(cap_wr == 2, "R10", "restart ignored cap writes", cap_wr, 2);

    // R8/R9: link never comes up
    init_model(1, 2);
    pulse_start(2'd1);
    wait_end();
    @(negedge clk);
    chk(fail && !done, "R8", "fail on link timeout", {done, fail}, 2'b01);
    chk(cur_speed == 0, "R8", "speed cleared", cur_speed, 0);
    chk(dbg_rd == LINK_TRIES, "R8", "debug read count", dbg_rd, LINK_TRIES);
    chk(phy_rd_n == 2 && phy_wr_n == 2, "R9", "PHY access count", {phy_rd_n[7:0], phy_wr_n[7:0]}, 16'h0202);
    chk(phy_w1 == (PHY_INIT | 16'h0028), "R9", "override set value", phy_w1, PHY_INIT | 16'h0028);
    chk(phy_w2 == PHY_INIT, "R9", "override clear value", phy_w2, PHY_INIT);
    chk((t_r2 - t_w1) >= RECOV_CYC, "R9", "override hold time", t_r2 - t_w1, RECOV_CYC);
    chk(phy_addr_bad == 0, "R9", "PHY address", phy_addr_bad, 0);
    chk(hold_bad == 0, "R11", "request hold on PHY port", hold_bad, 0);
    repeat (20) @(negedge clk);
    chk(fail && !done, "R10", "fail sticky", {done, fail}, 2'b01);

    // R6: speed change never completes
    init_model(2, 2);
    pulse_start(2'd2);
    wait_end();
    @(negedge clk);
    chk(fail && !done, "R6", "fail on speed change timeout", {done, fail}, 2'b01);
    chk(ctrl_rd == SPD_TRIES + 1, "R6", "ctrl read count", ctrl_rd, SPD_TRIES + 1);
    chk(phy_w1 == (PHY_INIT | 16'h0028) && phy_w2 == PHY_INIT, "R9", "override after speed fail",
        {phy_w1, phy_w2}, {PHY_INIT | 16'h0028, PHY_INIT});

    // recovery: a normal run after failure clears fail
    init_model(0, 1);
    pulse_start(2'd2);
    wait_end();
    @(negedge clk);
    chk(done && !fail && cur_speed == 4'd1, "R10", "run after failure", {done, fail, cur_speed}, 6'b10_0001);

    finish_run();
  end

endmodule